// File: doc/BRIEF.md
# Page table address translator

This block turns a virtual address into a physical address through a single-level page table kept in internal register storage. Each incoming request carries a virtual address and an access type. The translator splits the address into a page number and an offset. It uses the page number to select one table entry, checks the entry's valid and permission bits, and answers one cycle later. The answer is either a physical address or a fault. A fault is reported as a page fault when the entry is invalid, or as a protection fault when the access type is not allowed.

Each entry also carries two status bits, referenced and modified. A successful access updates them in place on the same clock edge that registers the response. A controlling agent fills the table through a configuration write port. A configuration write either clears the two status bits or loads them with supplied values. The response also returns the entry's status bits as they stand after the access, so the agent can watch page usage through the normal interface.

Top module: `page_xlate`

## Requirements
- R1: The virtual address bits [15:8] form the page number that selects one of 256 entries. The bits [7:0] form the page offset.
- R2: A request presented with `req_valid` high in one cycle produces `rsp_valid` high in exactly the following cycle. `rsp_valid` is low after any cycle with no request.
- R3: A successful translation returns `rsp_paddr` = {entry frame number, unchanged offset}, with both fault flags low.
- R4: When the selected entry's valid bit is clear, the response has `rsp_pfault`=1, `rsp_xfault`=0 and `rsp_paddr`=0, and the entry's status bits are not changed. A page fault takes precedence over a protection fault.
- R5: A successful access of any type (read, write or execute) sets the entry's referenced bit. `rsp_ref` and `rsp_mod` report the entry's status bits after the access, and report them unchanged on a fault.
- R6: The modified bit is set only by a successful write. Reads, executes and faulting accesses leave it unchanged.
- R7: `req_kind` is coded as 00 read, 01 write, 10 execute and 11 reserved. The permission bits are `cfg_perm[0]` read, `cfg_perm[1]` write and `cfg_perm[2]` execute. An access on a valid entry whose type is not permitted, or whose type is reserved, gives `rsp_xfault`=1, `rsp_pfault`=0 and `rsp_paddr`=0, and the status bits are not updated.
- R8: A configuration write with `cfg_we`=1 loads the valid bit, permissions and frame of entry `cfg_index`. The write clears the referenced and modified bits, unless `cfg_status_en`=1, in which case it loads them from `cfg_ref` and `cfg_mod`.
- R9: A configuration write and a status write-back to the same entry on the same edge resolve in favour of the configuration write. The concurrent response is computed from the entry's old contents.
- R10: Reset makes every entry invalid with cleared status bits, and holds `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_index | input | 8 | Entry written |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_frame | input | 8 | Frame number to store |
| cfg_status_en | input | 1 | Load the status bits from cfg_ref/cfg_mod instead of clearing them |
| cfg_ref | input | 1 | Referenced bit to load |
| cfg_mod | input | 1 | Modified bit to load |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 16 | Physical address, zero on a fault |
| rsp_pfault | output | 1 | Entry not valid |
| rsp_xfault | output | 1 | Access type not permitted |
| rsp_ref | output | 1 | Entry referenced bit after the access |
| rsp_mod | output | 1 | Entry modified bit after the access |

## Verification
Each result of this block lands on the first rising edge after its stimulus. That holds for the response to a request, for the status write-back that the next response to the same entry reveals, and for a configuration write that the next request observes. The bench drives every stimulus on a falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. The bench keeps its own model of the table and updates it only after each comparison. The collision case is then checked in two steps. The colliding response is compared against the old entry. A later access is compared against the newly written one.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 8,
  parameter int PFN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic [1:0]             req_kind,
  input  logic                   cfg_we,
  input  logic [VA_W-OFF_W-1:0]  cfg_index,
  input  logic                   cfg_valid,
  input  logic [2:0]             cfg_perm,
  input  logic [PFN_W-1:0]       cfg_frame,
  input  logic                   cfg_status_en,
  input  logic                   cfg_ref,
  input  logic                   cfg_mod,
  output logic                   rsp_valid,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_pfault,
  output logic                   rsp_xfault,
  output logic                   rsp_ref,
  output logic                   rsp_mod
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int ENTRIES = 1 << VPN_W;
  localparam int PA_W    = PFN_W + OFF_W;

  logic             ent_v    [ENTRIES];
  logic [2:0]       ent_perm [ENTRIES];
  logic [PFN_W-1:0] ent_pfn  [ENTRIES];
  logic             ent_ref  [ENTRIES];
  logic             ent_mod  [ENTRIES];

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic             allowed, hit_ok, pf, xf, nxt_ref, nxt_mod;

  assign vpn = req_vaddr[VA_W-1:OFF_W];
  assign off = req_vaddr[OFF_W-1:0];

  always_comb begin
    case (req_kind)
      2'd0:    allowed = ent_perm[vpn][0];
      2'd1:    allowed = ent_perm[vpn][1];
      2'd2:    allowed = ent_perm[vpn][2];
      default: allowed = 1'b0;
    endcase
  end

  assign pf      = !ent_v[vpn];
  assign xf      = ent_v[vpn] && !allowed;
  assign hit_ok  = ent_v[vpn] && allowed;
  assign nxt_ref = ent_ref[vpn] | hit_ok;
  assign nxt_mod = ent_mod[vpn] | (hit_ok && req_kind == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_v[i]    <= 1'b0;
        ent_perm[i] <= '0;
        ent_pfn[i]  <= '0;
        ent_ref[i]  <= 1'b0;
        ent_mod[i]  <= 1'b0;
      end
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_pfault <= 1'b0;
      rsp_xfault <= 1'b0;
      rsp_ref    <= 1'b0;
      rsp_mod    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr  <= hit_ok ? {ent_pfn[vpn], off} : {PA_W{1'b0}};
        rsp_pfault <= pf;
        rsp_xfault <= xf;
        rsp_ref    <= nxt_ref;
        rsp_mod    <= nxt_mod;
        if (hit_ok) begin
          ent_ref[vpn] <= nxt_ref;
          ent_mod[vpn] <= nxt_mod;
        end
      end
      if (cfg_we) begin
        ent_v[cfg_index]    <= cfg_valid;
        ent_perm[cfg_index] <= cfg_perm;
        ent_pfn[cfg_index]  <= cfg_frame;
        ent_ref[cfg_index]  <= cfg_status_en & cfg_ref;
        ent_mod[cfg_index]  <= cfg_status_en & cfg_mod;
      end
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 8,
  parameter int PFN_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [VA_W-1:0]        req_vaddr,
  input logic [1:0]             req_kind,
  input logic                   rsp_valid,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input logic                   rsp_pfault,
  input logic                   rsp_xfault,
  input logic                   rsp_ref,
  input logic                   rsp_mod
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_pfault || rsp_xfault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_pfault) |-> (rsp_paddr == '0 && !rsp_xfault)); // R4
  AST_REF_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_pfault || rsp_xfault || rsp_ref)); // R5
  AST_MOD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |=> (rsp_pfault || rsp_xfault || rsp_mod)); // R6
  AST_RESERVED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=> (rsp_pfault || rsp_xfault)); // R7
  AST_PROT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_xfault) |-> (rsp_paddr == '0)); // R7
endmodule

bind page_xlate page_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_pfault(rsp_pfault), .rsp_xfault(rsp_xfault),
  .rsp_ref(rsp_ref), .rsp_mod(rsp_mod)
);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_index = '0;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_perm = '0;
  logic [7:0]  cfg_frame = '0;
  logic        cfg_status_en = 1'b0, cfg_ref = 1'b0, cfg_mod = 1'b0;
  logic        rsp_valid, rsp_pfault, rsp_xfault, rsp_ref, rsp_mod;
  logic [15:0] rsp_paddr;

  page_xlate u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic       m_v [256];
  logic [2:0] m_perm [256];
  logic [7:0] m_pfn [256];
  logic       m_ref [256];
  logic       m_mod [256];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic v, input logic [2:0] p,
                           input logic [7:0] f, input logic se, input logic r, input logic m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_index = idx; cfg_valid = v; cfg_perm = p; cfg_frame = f;
    cfg_status_en = se; cfg_ref = r; cfg_mod = m;
    @(negedge clk);
    cfg_we = 1'b0;
    m_v[idx] = v; m_perm[idx] = p; m_pfn[idx] = f;
    m_ref[idx] = se & r; m_mod[idx] = se & m;
  endtask

  task automatic access(input logic [15:0] va, input logic [1:0] kind);
    logic [7:0] idx;
    logic ok, al, epf, exf, er, em;
    logic [15:0] epa;
    idx = va[15:8];
    al  = (kind == 2'd3) ? 1'b0 : m_perm[idx][kind];
    ok  = m_v[idx] && al;
    epf = !m_v[idx];
    exf = m_v[idx] && !al;
    epa = ok ? {m_pfn[idx], va[7:0]} : 16'h0;
    er  = m_ref[idx] | ok;
    em  = m_mod[idx] | (ok && kind == 2'd1);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid, "R2 rsp_valid", 32'(rsp_valid), 32'd1);
    chk({rsp_pfault, rsp_xfault, rsp_paddr} == {epf, exf, epa},
        epf ? "R4 page fault" : (exf ? "R7 protection fault" : "R1 R3 translation"),
        32'({rsp_pfault, rsp_xfault, rsp_paddr}), 32'({epf, exf, epa}));
    chk({rsp_ref, rsp_mod} == {er, em}, "R5 R6 R8 status bits",
        32'({rsp_ref, rsp_mod}), 32'({er, em}));
    m_ref[idx] = er; m_mod[idx] = em;
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_v[i] = 0; m_perm[i] = 0; m_pfn[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!rsp_valid, "R10 rsp_valid low after reset", 32'(rsp_valid), 32'd0);
    // R10: untouched entries are invalid after reset
    access(16'h0000, 2'd0);
    access(16'hFF7F, 2'd2);

    for (int i = 0; i < 256; i++) begin
      cfg_write(8'(i), (i % 5) != 0, 3'(i), 8'(i * 37 + 11), (i % 3) == 0, i[3], i[4]);
    end

    for (int i = 0; i < 256; i++) begin
      for (int k = 2; k >= 0; k--) access({8'(i), 8'(i * 13 + k)}, 2'(k));
      access({8'(i), 8'(i * 7)}, 2'd3);
      access({8'(i), 8'hA5}, 2'd2);
    end

    @(negedge clk);
    chk(!rsp_valid, "R2 no response without request", 32'(rsp_valid), 32'd0);

    // R8: a rewrite without status load clears status
    cfg_write(8'd77, 1'b1, 3'b111, 8'h3C, 1'b0, 1'b1, 1'b1);
    access(16'h4D10, 2'd2);
    // R8: a rewrite with status load sets status
    cfg_write(8'd78, 1'b1, 3'b001, 8'h3D, 1'b1, 1'b1, 1'b1);
    access(16'h4E20, 2'd1);

    // R9: collision between configuration write and write-back
    cfg_write(8'd200, 1'b1, 3'b111, 8'h42, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'hC855; req_kind = 2'd1;
    cfg_we = 1'b1; cfg_index = 8'd200; cfg_valid = 1'b1; cfg_perm = 3'b111;
    cfg_frame = 8'h99; cfg_status_en = 1'b0; cfg_ref = 1'b0; cfg_mod = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk(rsp_valid && rsp_paddr == 16'h4255 && !rsp_pfault && !rsp_xfault,
        "R9 old entry used", 32'(rsp_paddr), 32'h4255);
    chk({rsp_ref, rsp_mod} == 2'b11, "R9 old status updated", 32'({rsp_ref, rsp_mod}), 32'd3);
    m_v[200] = 1; m_perm[200] = 3'b111; m_pfn[200] = 8'h99; m_ref[200] = 0; m_mod[200] = 0;
    access(16'hC801, 2'd2);
    chk(rsp_mod == 1'b0, "R9 config write wins", 32'(rsp_mod), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule